// File: doc/BRIEF.md
# Multidrop Serial Transmitter with Address/Data Tag

This block is the transmit half of a serial port for the master on a shared multidrop line. Software writes a mode register, then hands bytes to a one-entry holding buffer. Each byte becomes a frame on the line. In multidrop operation an extra tag bit follows the data bits. The tag tells every listening slave whether the character is a slave address (tag 1) or data for the slave already addressed (tag 0). Outside multidrop operation that slot is left out, and the data bits are followed directly by the stop bits.

The tag value, data length and stop count are captured together with the byte at the moment it enters the holding buffer. The mode register can therefore be rewritten for the next character while the current one is still queued or on the line. A transmit enable controls whether queued characters are started. A ready flag tells software when the holding buffer can take another byte. Bit timing comes from a free-running clock-enable divider, with each bit held for 16 of its ticks.

Top module: `mdrop_tx`

## Requirements
- R1: After reset the line `txd` is high, the holding buffer is empty and the mode register is all zeros. With `tx_en` low, `tx_ready` is 0.
- R2: A frame is, in line order: one low start bit, then the data bits least significant first, then (in multidrop operation only) the tag bit, then the high stop bits. Between frames the line is high.
- R3: Multidrop operation applies exactly when mode bits [4:3] equal 2'b11. For any other value of that field, the frame carries no tag slot.
- R4: The tag bit equals mode bit 2 as it stood when the byte was accepted into the holding buffer (1 = address, 0 = data). Rewriting the mode register afterwards does not change a queued or in-flight character.
- R5: Mode bits [1:0] set the data length: 2'b00 = 5, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8 bits. Byte bits above the length are not sent.
- R6: Mode bit 5 selects the number of stop bits: 0 gives one stop bit, 1 gives two.
- R7: `tx_ready` is high exactly when `tx_en` is high and the holding buffer is empty. It is low in the cycle after an accepted write, and rises again once the buffered character moves into the shifter.
- R8: A write presented while `tx_ready` is low is ignored: no frame is ever sent for it, and the buffered character is unchanged.
- R9: While `tx_en` is low, no new frame starts and a buffered character stays queued. A frame already on the line finishes. The queued character is sent once `tx_en` returns high.
- R10: The divider gives one tick every `BAUD_DIV` clocks. Every bit lasts 16 ticks, except that the start bit may be shortened by less than one tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 6 | Mode value: [5] two stops, [4:3] parity mode, [2] tag, [1:0] length |
| wr_valid | input | 1 | Byte write strobe to the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Holding buffer can accept a byte |
| txd | output | 1 | Serial line output, idle high |

## Verification
The hardest situation to reach from the ports is a character sitting in the holding buffer while the mode register, the enable or a stray write changes underneath it. The stimulus loads one byte so that it goes straight into the shifter, then loads a second byte, which must stay queued behind the first frame. With that second character waiting, the bench rewrites the tag, forces a write with `tx_ready` low, and in another pass drops `tx_en` until the first frame has ended. The line monitor then checks that the queued frame still carries the settings from its own load and that the forced write never shows up as a frame.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_DATA = 5;
    localparam int OVS      = 16;
    localparam int FRAME_W  = 1 + DATA_W + 1 + 2;
    localparam int LEN_W    = $clog2(FRAME_W + 1);
    localparam int TICK_W   = $clog2(OVS);

    localparam logic [1:0] PM_MULTIDROP = 2'b11;

    typedef struct packed {
        logic       two_stop;
        logic [1:0] pmode;
        logic       tag;
        logic [1:0] len_code;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              multidrop;
        logic              tag;
        logic [1:0]        len_code;
        logic              two_stop;
    } char_t;

    function automatic logic [LEN_W-1:0] data_bits(input logic [1:0] len_code);
        return LEN_W'(MIN_DATA) + LEN_W'(len_code);
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input char_t c);
        logic [LEN_W-1:0] n;
        n = LEN_W'(1) + data_bits(c.len_code) + LEN_W'(c.multidrop);
        return n + (c.two_stop ? LEN_W'(2) : LEN_W'(1));
    endfunction

    function automatic logic [FRAME_W-1:0] frame_bits(input char_t c);
        logic [FRAME_W-1:0] f;
        int n;
        f    = '1;
        f[0] = 1'b0;
        n    = int'(data_bits(c.len_code));
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) f[1+i] = c.data[i];
        end
        if (c.multidrop) f[1+n] = c.tag;
        return f;
    endfunction

    function automatic char_t build_char(input mode_t m, input logic [DATA_W-1:0] d);
        char_t c;
        c.data      = d;
        c.multidrop = (m.pmode == PM_MULTIDROP);
        c.tag       = m.tag;
        c.len_code  = m.len_code;
        c.two_stop  = m.two_stop;
        return c;
    endfunction

endpackage

// File: rtl/mdrop_baud.sv
module mdrop_baud #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (DIV > 1) begin : g_tick_chk
            AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R10
        end
    endgenerate

endmodule

// File: rtl/mdrop_hold.sv
module mdrop_hold
    import mdrop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] wr_data,
    input  mode_t             mode,
    input  logic              take,
    output logic              full,
    output char_t             chr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            chr  <= '0;
        end else begin
            if (take) full <= 1'b0;
            if (accept) begin
                full <= 1'b1;
                chr  <= build_char(mode, wr_data);
            end
        end
    end

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(chr))); // R8

    AST_ACCEPT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        accept |-> !full); // R7

endmodule

// File: rtl/mdrop_shift.sv
module mdrop_shift
    import mdrop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  load,
    input  char_t chr,
    output logic  busy,
    output logic  txd
);
    logic [FRAME_W-1:0] sreg;
    logic [LEN_W-1:0]   bits_left;
    logic [TICK_W-1:0]  tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg      <= '1;
            bits_left <= '0;
            tcnt      <= '0;
            busy      <= 1'b0;
        end else if (load) begin
            sreg      <= frame_bits(chr);
            bits_left <= frame_len(chr);
            tcnt      <= '0;
            busy      <= 1'b1;
        end else if (busy && tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TICK_W'(OVS - 1)) begin
                sreg      <= {1'b1, sreg[FRAME_W-1:1]};
                bits_left <= bits_left - 1'b1;
                if (bits_left == LEN_W'(1)) busy <= 1'b0;
            end
        end
    end

    assign txd = busy ? sreg[0] : 1'b1;

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd); // R2

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bits_left != '0 && bits_left <= LEN_W'(FRAME_W))); // R2

    AST_BIT_STEADY: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !load) |=> $stable(txd)); // R10

    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load); // R7

endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx
    import mdrop_pkg::*;
#(
    parameter int BAUD_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_ready,
    output logic              txd
);
    mode_t mode_q;
    char_t held;
    logic  tick, full, busy, accept, take;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_we) mode_q <= mode_t'(mode_wdata);
    end

    assign tx_ready = tx_en && !full;
    assign accept   = wr_valid && tx_ready;
    assign take     = full && !busy && tx_en;

    mdrop_baud #(.DIV(BAUD_DIV)) u_baud (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    mdrop_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .wr_data(wr_data),
        .mode   (mode_q),
        .take   (take),
        .full   (full),
        .chr    (held)
    );

    mdrop_shift u_shift (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .load(take),
        .chr (held),
        .busy(busy),
        .txd (txd)
    );

    AST_READY_FALLS: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && tx_ready) |=> !tx_ready); // R7

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !busy) |=> txd); // R9

endmodule

// File: tb/sim_mdrop_tx.sv
module sim_mdrop_tx;

    localparam int DIV  = 3;
    localparam int BITC = 16 * DIV;
    localparam int HALF = 8 * DIV;
    localparam int MAXF = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       mode_we = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_ready, txd;

    always #2 clk = ~clk;

    mdrop_tx #(.BAUD_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .wr_valid(wr_valid), .wr_data(wr_data),
        .tx_ready(tx_ready), .txd(txd)
    );

    typedef struct {
        logic [MAXF-1:0] bits;
        int              len;
        string           req;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    int frames_done = 0;
    bit mon_busy = 0;

    logic [1:0] cur_pm = 2'b00, cur_len = 2'b00;
    logic       cur_tag = 1'b0, cur_stop2 = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic set_mode(input logic [1:0] pm, input logic tag, input logic [1:0] len, input logic st2);
        @(negedge clk);
        mode_we    = 1'b1;
        mode_wdata = {st2, pm, tag, len};
        @(negedge clk);
        mode_we = 1'b0;
        cur_pm = pm; cur_tag = tag; cur_len = len; cur_stop2 = st2;
    endtask

    function automatic exp_t expect_frame(input logic [7:0] d, input string req);
        exp_t e;
        int n, pos;
        e.bits = '1;
        e.bits[0] = 1'b0;
        n = 5 + int'(cur_len);
        for (int i = 0; i < n; i++) e.bits[1+i] = d[i];
        pos = 1 + n;
        if (cur_pm == 2'b11) begin
            e.bits[pos] = cur_tag;
            pos++;
        end
        e.len = pos + (cur_stop2 ? 2 : 1);
        e.req = req;
        return e;
    endfunction

    task automatic send(input logic [7:0] d, input string req);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        q.push_back(expect_frame(d, req));
        @(negedge clk);
        wr_valid = 1'b0;
        check(tx_ready == 1'b0, "R7 ready low after write", int'(tx_ready), 0);
    endtask

    task automatic wait_drain();
        while (q.size() != 0 || mon_busy) @(negedge clk);
        repeat (BITC) @(negedge clk);
    endtask

    // Monitor: decode the line and compare with the scoreboard
    logic prev_line = 1'b1;
    initial begin
        exp_t e;
        logic [MAXF-1:0] got, mask;
        int len, low_len;
        bit have, seen;
        forever begin
            @(negedge clk);
            if (!rst && prev_line && !txd) begin
                mon_busy = 1;
                if (q.size() == 0) begin
                    have = 0;
                    len  = MAXF;
                    check(1'b0, "R8 unexpected frame on line", 1, 0);
                end else begin
                    have = 1;
                    e    = q.pop_front();
                    len  = e.len;
                end
                got = '1; seen = 0; low_len = 0;
                for (int c = 1; c <= HALF - 1 + (len - 1) * BITC; c++) begin
                    @(negedge clk);
                    if (!seen && txd) begin
                        seen = 1;
                        low_len = c;
                    end
                    if (c >= HALF - 1 && ((c - (HALF - 1)) % BITC) == 0)
                        got[(c - (HALF - 1)) / BITC] = txd;
                end
                if (have) begin
                    mask = MAXF'((1 << len) - 1);
                    check((got & mask) == (e.bits & mask), e.req, int'(got & mask), int'(e.bits & mask));
                    if (e.bits[1])
                        check(low_len > 15 * DIV && low_len <= 16 * DIV,
                              "R10 start bit length", low_len, BITC);
                end
                frames_done++;
                mon_busy = 0;
                prev_line = txd;
            end else begin
                prev_line = txd;
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int fd;
        bit line_ok;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R1 line idle after reset", int'(txd), 1);
        check(tx_ready == 1'b0, "R1 ready low while disabled", int'(tx_ready), 0);
        tx_en = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1, "R7 ready when enabled and empty", int'(tx_ready), 1);

        // R2 R3 R5 R6: multidrop address, 8 bits, one stop
        set_mode(2'b11, 1'b1, 2'b11, 1'b0);
        send(8'hA5, "R2 multidrop address 8 bits");
        wait_drain();
        // data tag, 7 bits, two stops
        set_mode(2'b11, 1'b0, 2'b10, 1'b1);
        send(8'h5B, "R6 data 7 bits two stops");
        send(8'hC3, "R6 back to back two stops");
        wait_drain();
        // 5 and 6 data bits
        set_mode(2'b11, 1'b1, 2'b00, 1'b0);
        send(8'hF3, "R5 five data bits");
        set_mode(2'b11, 1'b0, 2'b01, 1'b0);
        send(8'h2D, "R5 six data bits");
        wait_drain();
        // R3: parity field not 11, no tag slot
        set_mode(2'b00, 1'b1, 2'b11, 1'b0);
        send(8'h81, "R3 no tag slot field 00");
        set_mode(2'b10, 1'b1, 2'b10, 1'b1);
        send(8'h7E, "R3 no tag slot field 10");
        wait_drain();

        // R4 and R8: queued character keeps its tag; stray write ignored
        set_mode(2'b11, 1'b1, 2'b11, 1'b0);
        send(8'h11, "R4 first address");
        send(8'h22, "R4 queued keeps tag 1");
        set_mode(2'b11, 1'b0, 2'b11, 1'b0);
        @(negedge clk);
        check(tx_ready == 1'b0, "R8 ready low while queued", int'(tx_ready), 0);
        wr_valid = 1'b1;
        wr_data  = 8'h3C;
        @(negedge clk);
        wr_valid = 1'b0;
        send(8'h33, "R4 later data tag 0");
        wait_drain();

        // R9: disable while a frame runs and another is queued
        set_mode(2'b11, 1'b1, 2'b10, 1'b0);
        fd = frames_done;
        send(8'h44, "R9 frame in flight finishes");
        send(8'h55, "R9 queued frame after re-enable");
        tx_en = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b0, "R9 ready low when disabled", int'(tx_ready), 0);
        while (frames_done == fd) @(negedge clk);
        line_ok = 1;
        for (int i = 0; i < 4 * BITC; i++) begin
            @(negedge clk);
            if (!txd || mon_busy) line_ok = 0;
        end
        check(line_ok, "R9 no start while disabled", int'(line_ok), 1);
        check(frames_done == fd + 1, "R9 only the running frame sent", frames_done - fd, 1);
        tx_en = 1'b1;
        wait_drain();
        check(q.size() == 0, "R8 all expected frames seen", q.size(), 0);

        finish_run();
    end

endmodule